// File: doc/BRIEF.md
# Late-Write Synchronous SRAM

This block is a single-port synchronous static memory that uses the late-write protocol. Each access is set up by an address, a chip select, a write strobe and per-byte lane enables, all sampled on a rising clock edge. For a write, the data follows one edge later. A small pending-write stage holds the address and lane enables across that gap. It then commits the incoming data to the array on the edge that samples it. A new access can be captured on that same edge, so writes stream back to back with no idle cycles.

Reads are register to register. The array word is captured into an output register on the same edge that samples the read address. If the read address matches a write that is still waiting for its data, the enabled lanes are taken from the write data arriving on that edge. Lanes that are not enabled come from the array. A read that follows a write closely therefore never returns stale data. An output enable gates the data bus combinationally and reports the bus-drive state on a separate pin. A sleep input and the chip select both block new accesses. Neither stops a write that is already pending from completing.

Default geometry is 1024 words of two 9-bit lanes. Depth, lane count and lane width are parameters, so the same block covers a 256K x 18 or a four-lane 36-bit arrangement.

Top module: `lw_sram`

## Requirements
- R1: Access type is decided from sel_i, we_i and sleep_i as sampled on a rising clk_i edge. rdata_o does not change between edges.
- R2: For a write captured on edge k, wdata_i sampled on edge k+1 is committed to the captured address.
- R3: be_i bit i enables lane i (bits [i*9+8:i*9] by default). Lanes whose enable is low keep their stored value.
- R4: A read captured on edge k shows the word on rdata_o right after edge k. The value holds until the next read edge.
- R5: A read whose address equals a pending write's address returns the enabled lanes from wdata_i on that edge and the other lanes from the array.
- R6: A new write may be captured on the edge that commits the previous write. Both words are stored correctly.
- R7: With sel_i low, nothing is read or written and rdata_o holds. A write pending from the previous cycle still commits.
- R8: With sleep_i high, no new read or write is accepted. A write pending from the previous cycle still commits.
- R9: With oe_i low, rdata_oe_o is 0 and rdata_o is 0 at once, independent of the clock. Raising oe_i restores the held word.
- R10: After reset, no write is pending and the output register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Chip select, active high |
| we_i | input | 1 | Write strobe (1 write, 0 read) |
| be_i | input | NB | Per-lane write enables |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | NB*BYTE_W | Write data, one edge after its address |
| sleep_i | input | 1 | Blocks new accesses while high |
| oe_i | input | 1 | Asynchronous output enable |
| rdata_o | output | NB*BYTE_W | Read data, zero while disabled |
| rdata_oe_o | output | 1 | Bus drive indication |

## Verification
Four behaviours are checked by assertions on every cycle. The pending flag must follow an accepted write and clear after idle or sleep cycles. The output register must hold across non-read cycles. A full-lane bypass read must return the data arriving on that edge. A low output enable must blank the bus. Only the bench scenarios can show that the stored contents are right. That covers lane-masked updates, back-to-back write streams, partial-lane bypass merges, commits that complete under deselect or sleep, and the way read data is placed relative to the clock edge.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int NB     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic              sleep_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NB-1:0]     be_i,
  output op_e               op_o,
  output logic              pend_valid_o,
  output logic [ADDR_W-1:0] pend_addr_o,
  output logic [NB-1:0]     pend_be_o
);
  always_comb begin
    if (!sel_i || sleep_i) op_o = OP_IDLE;
    else if (we_i)         op_o = OP_WRITE;
    else                   op_o = OP_READ;
  end

  // pending write: address/lanes wait one edge for their data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_valid_o <= 1'b0;
      pend_addr_o  <= '0;
      pend_be_o    <= '0;
    end else begin
      pend_valid_o <= (op_o == OP_WRITE);
      if (op_o == OP_WRITE) begin
        pend_addr_o <= addr_i;
        pend_be_o   <= be_i;
      end
    end
  end
endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
  parameter int ADDR_W = 10,
  parameter int NB     = 2,
  parameter int BYTE_W = 9
) (
  input  logic                 clk_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [NB-1:0]        wr_be_i,
  input  logic [NB*BYTE_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic [NB*BYTE_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_be_i[g])
        mem[wr_addr_i] <= wr_data_i[g*BYTE_W +: BYTE_W];
    end

    assign rd_data_o[g*BYTE_W +: BYTE_W] = mem[rd_addr_i];
  end
endmodule

// File: rtl/lw_sram_rdpath.sv
module lw_sram_rdpath #(
  parameter int ADDR_W = 10,
  parameter int NB     = 2,
  parameter int BYTE_W = 9
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  input  logic [NB*BYTE_W-1:0] arr_data_i,
  input  logic                 pend_valid_i,
  input  logic [ADDR_W-1:0]    pend_addr_i,
  input  logic [NB-1:0]        pend_be_i,
  input  logic [NB*BYTE_W-1:0] wdata_i,
  input  logic                 oe_i,
  output logic [NB*BYTE_W-1:0] rd_q_o,
  output logic [NB*BYTE_W-1:0] rdata_o,
  output logic                 rdata_oe_o
);
  localparam int DW = NB * BYTE_W;

  logic            hit;
  logic [DW-1:0]   merged;

  assign hit = pend_valid_i && (pend_addr_i == rd_addr_i);

  // bypass: lanes being committed this edge come from the write bus
  for (genvar g = 0; g < NB; g++) begin : g_merge
    assign merged[g*BYTE_W +: BYTE_W] = (hit && pend_be_i[g])
                                        ? wdata_i[g*BYTE_W +: BYTE_W]
                                        : arr_data_i[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q_o <= '0;
    else if (rd_en_i) rd_q_o <= merged;
  end

  assign rdata_oe_o = oe_i;
  assign rdata_o    = oe_i ? rd_q_o : '0;
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int NB     = 2,
  parameter int BYTE_W = 9
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sel_i,
  input  logic                 we_i,
  input  logic [NB-1:0]        be_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NB*BYTE_W-1:0] wdata_i,
  input  logic                 sleep_i,
  input  logic                 oe_i,
  output logic [NB*BYTE_W-1:0] rdata_o,
  output logic                 rdata_oe_o
);
  localparam int DW = NB * BYTE_W;

  op_e               op;
  logic              pend_valid;
  logic [ADDR_W-1:0] pend_addr;
  logic [NB-1:0]     pend_be;
  logic [DW-1:0]     arr_data;
  logic [DW-1:0]     rd_q;

  lw_sram_ctrl #(.ADDR_W(ADDR_W), .NB(NB)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_i        (sel_i),
    .we_i         (we_i),
    .sleep_i      (sleep_i),
    .addr_i       (addr_i),
    .be_i         (be_i),
    .op_o         (op),
    .pend_valid_o (pend_valid),
    .pend_addr_o  (pend_addr),
    .pend_be_o    (pend_be)
  );

  lw_sram_array #(.ADDR_W(ADDR_W), .NB(NB), .BYTE_W(BYTE_W)) u_array (
    .clk_i     (clk_i),
    .wr_en_i   (pend_valid),
    .wr_addr_i (pend_addr),
    .wr_be_i   (pend_be),
    .wr_data_i (wdata_i),
    .rd_addr_i (addr_i),
    .rd_data_o (arr_data)
  );

  lw_sram_rdpath #(.ADDR_W(ADDR_W), .NB(NB), .BYTE_W(BYTE_W)) u_rdpath (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_en_i      (op == OP_READ),
    .rd_addr_i    (addr_i),
    .arr_data_i   (arr_data),
    .pend_valid_i (pend_valid),
    .pend_addr_i  (pend_addr),
    .pend_be_i    (pend_be),
    .wdata_i      (wdata_i),
    .oe_i         (oe_i),
    .rd_q_o       (rd_q),
    .rdata_o      (rdata_o),
    .rdata_oe_o   (rdata_oe_o)
  );
endmodule

// File: rtl/lw_sram_checker.sv
module lw_sram_checker #(
  parameter int ADDR_W = 10,
  parameter int NB     = 2,
  parameter int BYTE_W = 9
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 sel_i,
  input logic                 we_i,
  input logic                 sleep_i,
  input logic                 oe_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [NB*BYTE_W-1:0] wdata_i,
  input logic [NB*BYTE_W-1:0] rdata_o,
  input logic                 rdata_oe_o,
  input logic                 pend_valid,
  input logic [ADDR_W-1:0]    pend_addr,
  input logic [NB-1:0]        pend_be,
  input logic [NB*BYTE_W-1:0] rd_q
);
  assert_pend_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && !sleep_i) |=> pend_valid);

  assert_no_new_access_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i || !sel_i) |=> !pend_valid);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && !we_i && !sleep_i) |=> $stable(rd_q));

  assert_bypass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !we_i && !sleep_i && pend_valid && pend_addr == addr_i && (&pend_be))
    |=> rd_q == $past(wdata_i));

  assert_oe_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> (!rdata_oe_o && rdata_o == '0));
endmodule

bind lw_sram lw_sram_checker #(.ADDR_W(ADDR_W), .NB(NB), .BYTE_W(BYTE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_i      (sel_i),
  .we_i       (we_i),
  .sleep_i    (sleep_i),
  .oe_i       (oe_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .rdata_oe_o (rdata_oe_o),
  .pend_valid (pend_valid),
  .pend_addr  (pend_addr),
  .pend_be    (pend_be),
  .rd_q       (rd_q)
);

// File: tb/lw_sram_bench.sv
module lw_sram_bench;
  localparam int ADDR_W = 10;
  localparam int NB     = 2;
  localparam int BYTE_W = 9;
  localparam int DW     = NB * BYTE_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              sel_i = 1'b0, we_i = 1'b0, sleep_i = 1'b0, oe_i = 1'b1;
  logic [NB-1:0]     be_i = '0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DW-1:0]     wdata_i = '0;
  logic [DW-1:0]     rdata_o;
  logic              rdata_oe_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  lw_sram u_lw_sram (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i), .be_i(be_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .sleep_i(sleep_i), .oe_i(oe_i),
    .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle at negedge, return 1 ns after the rising edge
  task automatic step(logic s, logic w, logic [NB-1:0] b, logic [ADDR_W-1:0] a,
                      logic [DW-1:0] d, logic slp = 1'b0);
    @(negedge clk_i);
    sel_i = s; we_i = w; be_i = b; addr_i = a; wdata_i = d; sleep_i = slp;
    @(posedge clk_i);
    #1;
  endtask

  function automatic logic [DW-1:0] w2(logic [8:0] hi, logic [8:0] lo);
    return {hi, lo};
  endfunction

  task automatic wr_full(logic [ADDR_W-1:0] a, logic [DW-1:0] d);
    step(1, 1, 2'b11, a, '0);
    step(0, 0, 2'b00, '0, d);
  endtask

  task automatic rd(logic [ADDR_W-1:0] a);
    step(1, 0, 2'b00, a, '0);
  endtask

  task automatic t_reset;
    check("R10 reset output", rdata_o, '0);
    check("R9 oe high drives", {17'd0, rdata_oe_o}, 18'd1);
  endtask

  task automatic t_basic;
    wr_full(10'd5, w2(9'h155, 9'h0AA));
    rd(10'd5);
    check("R2 write then read", rdata_o, w2(9'h155, 9'h0AA));
  endtask

  task automatic t_lanes;
    step(1, 1, 2'b01, 10'd5, '0);
    step(0, 0, 2'b00, '0, w2(9'h1FF, 9'h033));
    rd(10'd5);
    check("R3 low lane only", rdata_o, w2(9'h155, 9'h033));
    step(1, 1, 2'b10, 10'd5, '0);
    step(0, 0, 2'b00, '0, w2(9'h044, 9'h1FF));
    rd(10'd5);
    check("R3 high lane only", rdata_o, w2(9'h044, 9'h033));
  endtask

  task automatic t_bypass;
    wr_full(10'd7, w2(9'h011, 9'h022));
    step(1, 1, 2'b10, 10'd7, '0);
    step(1, 0, 2'b00, 10'd7, w2(9'h0EE, 9'h1DD));   // read on commit edge
    check("R5 partial bypass merge", rdata_o, w2(9'h0EE, 9'h022));
    step(1, 1, 2'b11, 10'd7, '0);
    step(1, 0, 2'b00, 10'd7, w2(9'h123, 9'h045));
    check("R5 full bypass", rdata_o, w2(9'h123, 9'h045));
    rd(10'd7);
    check("R5 committed after bypass", rdata_o, w2(9'h123, 9'h045));
  endtask

  task automatic t_stream;
    step(1, 1, 2'b11, 10'd10, '0);
    step(1, 1, 2'b11, 10'd11, w2(9'h0A0, 9'h00A));
    step(1, 1, 2'b11, 10'd12, w2(9'h0B0, 9'h00B));
    step(0, 0, 2'b00, '0, w2(9'h0C0, 9'h00C));
    rd(10'd10);
    check("R6 stream word 0", rdata_o, w2(9'h0A0, 9'h00A));
    rd(10'd11);
    check("R6 stream word 1", rdata_o, w2(9'h0B0, 9'h00B));
    rd(10'd12);
    check("R6 stream word 2", rdata_o, w2(9'h0C0, 9'h00C));
  endtask

  task automatic t_latency;
    // rdata_o still holds word 12 until the edge that samples the read
    @(negedge clk_i);
    sel_i = 1; we_i = 0; addr_i = 10'd10; sleep_i = 0;
    #1;
    check("R1 no change before edge", rdata_o, w2(9'h0C0, 9'h00C));
    @(posedge clk_i);
    #1;
    check("R4 data right after read edge", rdata_o, w2(9'h0A0, 9'h00A));
  endtask

  task automatic t_deselect;
    wr_full(10'd20, w2(9'h077, 9'h088));
    step(1, 1, 2'b11, 10'd21, '0);
    step(0, 1, 2'b11, 10'd20, w2(9'h066, 9'h055)); // commit 21; deselected write to 20
    step(0, 0, 2'b00, 10'd20, w2(9'h1AA, 9'h1BB)); // stray data, nothing pending
    check("R7 output holds while deselected", rdata_o, w2(9'h0A0, 9'h00A));
    rd(10'd21);
    check("R7 pending completes on deselect", rdata_o, w2(9'h066, 9'h055));
    rd(10'd20);
    check("R7 deselected write ignored", rdata_o, w2(9'h077, 9'h088));
  endtask

  task automatic t_sleep;
    wr_full(10'd31, w2(9'h031, 9'h131));
    step(1, 1, 2'b11, 10'd30, '0);
    step(1, 1, 2'b11, 10'd31, w2(9'h030, 9'h130), 1'b1); // commit 30, new write blocked
    step(1, 0, 2'b00, 10'd30, w2(9'h1EE, 9'h1EE), 1'b1); // read blocked
    check("R8 read blocked in sleep", rdata_o, w2(9'h077, 9'h088));
    rd(10'd30);
    check("R8 pending completes in sleep", rdata_o, w2(9'h030, 9'h130));
    rd(10'd31);
    check("R8 write blocked in sleep", rdata_o, w2(9'h031, 9'h131));
  endtask

  task automatic t_oe;
    @(negedge clk_i);
    sel_i = 0;
    #0.5;
    oe_i = 0;
    #0.5;
    check("R9 oe low blanks data", rdata_o, '0);
    check("R9 oe low releases bus", {17'd0, rdata_oe_o}, '0);
    oe_i = 1;
    #0.5;
    check("R9 oe restore", rdata_o, w2(9'h031, 9'h131));
  endtask

  initial begin
    #10;
    t_reset();
    @(negedge clk_i);
    rst_ni = 1;
    t_basic();
    t_lanes();
    t_bypass();
    t_stream();
    t_latency();
    t_deselect();
    t_sleep();
    t_oe();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule